// File: doc/BRIEF.md
# Reply Timeout Encoder and Wait Timer

This block turns a requested reply timeout, given in microseconds, into a compact setting made of a 2-bit unit code and a 7-bit length. The unit code selects one of four power-of-two step sizes: 8, 16, 32 or 64 us. The length is the number of steps, rounded up and clamped. A zero request selects a built-in default setting.

Each new request runs through a short multi-cycle conversion, and `cfg_busy_o` stays high while it runs. When the request is accepted, the setting that was in force until then is reported back on `prev_us_o` as a microsecond value.

The wait timer runs from a 1 us tick enable. A start pulse, given when a request has finished transmitting, loads the timer with length times unit. A reply pulse stops the timer. If no reply arrives before the count runs out, a sticky timeout flag is raised.

Top module: `aux_tmo_timer`

## Requirements
- R1: After reset, `code_o` is 0, `len_o` is 69, `prev_us_o` is 0, and `cfg_busy_o`, `running_o` and `timeout_o` are all low.
- R2: A requested timeout of 0 us produces the default setting: unit code 0 and length 69.
- R3: The unit code is chosen from the request size. Up to 1016 us gives code 0 (8 us unit). Up to 2032 us gives code 1 (16 us unit). Up to 4064 us gives code 2 (32 us unit). Anything larger gives code 3 (64 us unit).
- R4: For a nonzero request, the length is the request divided by the unit, rounded up whenever there is a remainder. The length is therefore never 0.
- R5: The length is clamped to a maximum of 127.
- R6: In the cycle after a request is accepted, `prev_us_o` shows the setting that was in force before it, as length × unit in microseconds. The default setting reads as 552.
- R7: A request is accepted only while `cfg_busy_o` is low. `cfg_busy_o` is then high for exactly two cycles, and the new code and length appear in the cycle it falls. A `cfg_valid_i` pulse while busy is ignored.
- R8: A `start_i` pulse loads length × unit, sets `running_o` and clears `timeout_o`. Each `tick_i` cycle while running counts down by one. The tick that brings the count to zero drops `running_o` and raises `timeout_o`. `timeout_o` then stays high until the next start or reply pulse.
- R9: A `reply_i` pulse stops the timer and clears `timeout_o`. When `start_i` and `reply_i` arrive in the same cycle, `start_i` wins.
- R10: A reconfiguration does not change a timer that is already running. The new setting is used from the next `start_i` pulse onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 us tick enable |
| cfg_valid_i | input | 1 | New timeout request strobe |
| cfg_us_i | input | US_W | Requested timeout in microseconds |
| cfg_busy_o | output | 1 | Conversion in progress |
| prev_us_o | output | OUT_W | Previous setting in microseconds |
| code_o | output | 2 | Current unit code |
| len_o | output | 7 | Current length |
| start_i | input | 1 | Request transmitted; start the wait |
| reply_i | input | 1 | Reply received; stop the wait |
| running_o | output | 1 | Timer counting |
| timeout_o | output | 1 | Sticky expiry flag |

## Verification
The conversion is tried with zero, with requests at and one step past each range limit (1016/1017, 2032/2033, 4064/4065), with small values on either side of a unit multiple (1, 8, 9), and with a request large enough to clamp. These tell apart an off-by-one range compare, floor versus ceiling rounding, a missing clamp and a missing default. Each request also checks the reported previous value against the setting before it. On the timer side, the count is stepped to one tick short of expiry and then to the expiry tick, which exposes an off-by-one load. Further runs cover a reply arriving mid-count and a reconfiguration made while the timer is running.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;
  localparam int unsigned CODE_W     = 2;
  localparam int unsigned LEN_W      = 7;
  localparam int unsigned BASE_SHIFT = 3;
  localparam int unsigned MAX_SHIFT  = BASE_SHIFT + (1 << CODE_W) - 1;
  localparam int unsigned OUT_W      = LEN_W + MAX_SHIFT;
  localparam int unsigned DEF_LEN    = 69;
  localparam int unsigned STEP_US    = 1016;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_COMMIT = 2'd2
  } enc_state_e;
endpackage

// File: rtl/aux_tmo_decode.sv
module aux_tmo_decode
  import aux_tmo_pkg::*;
#(
  parameter int unsigned OUT_BITS = OUT_W
) (
  input  logic [CODE_W-1:0]   code_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [OUT_BITS-1:0] us_o
);
  logic [$clog2(MAX_SHIFT+1)-1:0] sh;

  always_comb begin
    sh   = ($clog2(MAX_SHIFT+1))'(BASE_SHIFT) + ($clog2(MAX_SHIFT+1))'(code_i);
    us_o = OUT_BITS'(len_i) << sh;
  end
endmodule

// File: rtl/aux_tmo_encode.sv
module aux_tmo_encode
  import aux_tmo_pkg::*;
#(
  parameter int unsigned US_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [US_W-1:0]   cfg_us_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [US_W-1:0] LIM0    = US_W'(STEP_US);
  localparam logic [US_W-1:0] LIM1    = US_W'(2 * STEP_US);
  localparam logic [US_W-1:0] LIM2    = US_W'(4 * STEP_US);
  localparam logic [US_W-1:0] MAX_LEN = US_W'((1 << LEN_W) - 1);
  localparam int unsigned     SH_W    = $clog2(MAX_SHIFT + 1);

  enc_state_e        state_q;
  logic [US_W-1:0]   req_q;
  logic [US_W-1:0]   raw_q;
  logic [CODE_W-1:0] code_n_q;
  logic              zero_q;

  logic [CODE_W-1:0] code_c;
  logic [SH_W-1:0]   sh_c;
  logic [US_W-1:0]   mask_c;
  logic [US_W-1:0]   raw_c;

  assign accept_o = (state_q == ST_IDLE) && cfg_valid_i;
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    if (req_q <= LIM0)      code_c = 2'd0;
    else if (req_q <= LIM1) code_c = 2'd1;
    else if (req_q <= LIM2) code_c = 2'd2;
    else                    code_c = 2'd3;
    sh_c   = SH_W'(BASE_SHIFT) + SH_W'(code_c);
    mask_c = ({{(US_W-1){1'b0}}, 1'b1} << sh_c) - 1'b1;
    // ceiling: add one when any bit below the unit is set
    raw_c  = (req_q >> sh_c) + US_W'(|(req_q & mask_c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      req_q    <= '0;
      raw_q    <= '0;
      code_n_q <= '0;
      zero_q   <= 1'b0;
      code_o   <= '0;
      len_o    <= LEN_W'(DEF_LEN);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_valid_i) begin
            req_q   <= cfg_us_i;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          raw_q    <= raw_c;
          code_n_q <= code_c;
          zero_q   <= (req_q == '0);
          state_q  <= ST_COMMIT;
        end
        ST_COMMIT: begin
          if (zero_q) begin
            code_o <= '0;
            len_o  <= LEN_W'(DEF_LEN);
          end else begin
            code_o <= code_n_q;
            len_o  <= (raw_q > MAX_LEN) ? LEN_W'(MAX_LEN) : raw_q[LEN_W-1:0];
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_tmo_counter.sv
module aux_tmo_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             running_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      expired_o <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= load_i;
      running_o <= 1'b1;
      expired_o <= 1'b0;
    end else if (stop_i) begin
      running_o <= 1'b0;
      expired_o <= 1'b0;
    end else if (running_o && tick_i) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_q     <= '0;
        running_o <= 1'b0;
        expired_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_tmo_timer.sv
module aux_tmo_timer
  import aux_tmo_pkg::*;
#(
  parameter int unsigned US_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_valid_i,
  input  logic [US_W-1:0]   cfg_us_i,
  output logic              cfg_busy_o,
  output logic [OUT_W-1:0]  prev_us_o,
  output logic [CODE_W-1:0] code_o,
  output logic [LEN_W-1:0]  len_o,
  input  logic              start_i,
  input  logic              reply_i,
  output logic              running_o,
  output logic              timeout_o
);
  logic             accept;
  logic [OUT_W-1:0] cur_us;

  aux_tmo_encode #(.US_W(US_W)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_valid_i (cfg_valid_i),
    .cfg_us_i    (cfg_us_i),
    .accept_o    (accept),
    .busy_o      (cfg_busy_o),
    .code_o      (code_o),
    .len_o       (len_o)
  );

  aux_tmo_decode #(.OUT_BITS(OUT_W)) u_dec (
    .code_i (code_o),
    .len_i  (len_o),
    .us_o   (cur_us)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_us_o <= '0;
    else if (accept) prev_us_o <= cur_us;
  end

  aux_tmo_counter #(.CNT_W(OUT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .stop_i    (reply_i),
    .load_i    (cur_us),
    .running_o (running_o),
    .expired_o (timeout_o)
  );
endmodule

// File: rtl/aux_tmo_timer_chk.sv
module aux_tmo_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_busy_o,
  input logic [1:0] code_o,
  input logic [6:0] len_o,
  input logic       start_i,
  input logic       reply_i,
  input logic       running_o,
  input logic       timeout_o
);
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_busy_o) |=> cfg_busy_o ##1 !cfg_busy_o); // R7

  AST_SETTING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_busy_o && !$past(cfg_busy_o)) |-> ($stable(code_o) && $stable(len_o))); // R7

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o != 7'd0); // R4

  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (running_o && !timeout_o)); // R8

  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !start_i && !reply_i) |=> timeout_o); // R8

  AST_REPLY_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_i && !start_i) |=> (!running_o && !timeout_o)); // R9

  AST_RUN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_o && timeout_o)); // R8
endmodule

bind aux_tmo_timer aux_tmo_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_busy_o (cfg_busy_o),
  .code_o     (code_o),
  .len_o      (len_o),
  .start_i    (start_i),
  .reply_i    (reply_i),
  .running_o  (running_o),
  .timeout_o  (timeout_o)
);

// File: tb/aux_tmo_timer_tb_top.sv
module aux_tmo_timer_tb_top;
  localparam int US_W = 16;

  typedef struct {
    int us;
    int code;
    int len;
    int prev;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              cfg_valid_i = 1'b0;
  logic [US_W-1:0]   cfg_us_i = '0;
  logic              cfg_busy_o;
  logic [12:0]       prev_us_o;
  logic [1:0]        code_o;
  logic [6:0]        len_o;
  logic              start_i = 1'b0;
  logic              reply_i = 1'b0;
  logic              running_o;
  logic              timeout_o;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t sb_q[$];
  int   model_prev = 552;
  logic busy_d = 1'b0;

  always #2 clk_i = ~clk_i;

  aux_tmo_timer #(.US_W(US_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .cfg_valid_i(cfg_valid_i), .cfg_us_i(cfg_us_i), .cfg_busy_o(cfg_busy_o),
    .prev_us_o(prev_us_o), .code_o(code_o), .len_o(len_o),
    .start_i(start_i), .reply_i(reply_i),
    .running_o(running_o), .timeout_o(timeout_o)
  );

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic exp_t model(int us);
    exp_t e;
    int unit;
    e.us = us;
    if (us == 0) begin
      e.code = 0; e.len = 69;
    end else begin
      if (us <= 1016)      begin e.code = 0; unit = 8;  end
      else if (us <= 2032) begin e.code = 1; unit = 16; end
      else if (us <= 4064) begin e.code = 2; unit = 32; end
      else                 begin e.code = 3; unit = 64; end
      e.len = (us + unit - 1) / unit;
      if (e.len > 127) e.len = 127;
    end
    e.prev = model_prev;
    model_prev = e.len * (8 << e.code);
    return e;
  endfunction

  // driver: push expected item, strobe request
  task automatic cfg(int us);
    sb_q.push_back(model(us));
    @(negedge clk_i); cfg_valid_i = 1'b1; cfg_us_i = US_W'(us);
    @(negedge clk_i); cfg_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  // monitor: compare when conversion completes
  always @(negedge clk_i) begin
    if (busy_d && !cfg_busy_o) begin
      if (sb_q.size() == 0) begin
        check("R7 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check($sformatf("R3 code for %0d us", e.us), int'(code_o), e.code);
        check($sformatf("R4/R5/R2 len for %0d us", e.us), int'(len_o), e.len);
        check($sformatf("R6 prev for %0d us", e.us), int'(prev_us_o), e.prev);
      end
    end
    busy_d = cfg_busy_o;
  end

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk_i); tick_i = 1'b1; end
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic pulse_reply();
    @(negedge clk_i); reply_i = 1'b1;
    @(negedge clk_i); reply_i = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 code", int'(code_o), 0);
    check("R1 len", int'(len_o), 69);
    check("R1 prev", int'(prev_us_o), 0);
    check("R1 busy", int'(cfg_busy_o), 0);
    check("R1 running", int'(running_o), 0);
    check("R1 timeout", int'(timeout_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    cfg(1); cfg(8); cfg(9);
    cfg(1016); cfg(1017); cfg(2032); cfg(2033);
    cfg(4064); cfg(4065); cfg(9000); cfg(0);

    // R7 request while busy is ignored
    sb_q.push_back(model(100));
    @(negedge clk_i); cfg_valid_i = 1'b1; cfg_us_i = US_W'(100);
    @(negedge clk_i); cfg_us_i = US_W'(9000);
    check("R7 busy after accept", int'(cfg_busy_o), 1);
    @(negedge clk_i); cfg_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R7 queue drained", sb_q.size(), 0);
    check("R7 len kept", int'(len_o), 13);

    cfg(40); // len 5, unit 8
    // R8 expiry after exactly 40 ticks
    pulse_start();
    check("R8 running after start", int'(running_o), 1);
    ticks(39);
    check("R8 no timeout at 39", int'(timeout_o), 0);
    ticks(1);
    check("R8 timeout at 40", int'(timeout_o), 1);
    check("R8 stopped at 40", int'(running_o), 0);
    ticks(5);
    check("R8 sticky", int'(timeout_o), 1);
    pulse_start();
    check("R8 start clears", int'(timeout_o), 0);

    // R9 reply mid-count
    ticks(10);
    pulse_reply();
    check("R9 reply stops", int'(running_o), 0);
    check("R9 reply clears", int'(timeout_o), 0);
    ticks(50);
    check("R9 no late timeout", int'(timeout_o), 0);

    // R10 reconfigure while running
    pulse_start();
    ticks(5);
    cfg(8);
    ticks(34);
    check("R10 old load kept at 39", int'(timeout_o), 0);
    ticks(1);
    check("R10 old load expires at 40", int'(timeout_o), 1);
    pulse_start();
    ticks(7);
    check("R10 new load at 7", int'(timeout_o), 0);
    ticks(1);
    check("R10 new load at 8", int'(timeout_o), 1);

    repeat (3) @(negedge clk_i);
    report();
  end
endmodule